// File: doc/BRIEF.md
# CAN receive acceptance filter

This block sits behind a CAN bit-level receiver. When a frame has been fully received, the receiver presents the frame's identifier and its standard/extended flag for one cycle with a valid strobe. The block then decides in the same cycle whether the frame is kept and, if so, which of two receive buffers takes it. Six filters and two masks are checked against the identifier. Buffer 0 owns mask 0 and filters 0 and 1. Buffer 1 owns mask 1 and filters 2 to 5.

Each buffer has a receive flag that stays set until the consumer clears it. While a flag is set, that buffer is locked against new frames. Buffer 0 can optionally spill into buffer 1 when buffer 0 is occupied. Each buffer also has a 2-bit mode that selects which frame types it takes, or bypasses its filters entirely. For each buffer, a filter-hit register records which filter admitted the frame now held there.

Top module: `can_rx_accept_filter`

## Requirements
- R1: A mask bit of 1 makes the identifier bit take part in the compare, and the filter bit must equal it there. A mask bit of 0 makes that bit don't-care. Extended frames compare all 29 bits. Standard frames sit in bits [10:0] and compare only those bits, so bits [28:11] of the identifier, mask and filter are ignored for them.
- R2: Filter i matches only frames whose type equals its select bit `filt_ext[i]`: 1 means extended only, 0 means standard only.
- R3: Filters 0 and 1 use `mask0` and serve buffer 0. Filters 2 to 5 use `mask1` and serve buffer 1. When several filters of one buffer match, the lowest index wins, and the hit code is that filter's index (filter i sits at `filt_id[i*29 +: 29]`).
- R4: Buffer 0 is evaluated first. A frame that passes buffer 0 is never placed by buffer 1's filters, even when those filters also match, so a frame goes to at most one buffer.
- R5: Mode per buffer: 2'b11 accepts every frame with its filters bypassed and reports hit code 7. 2'b10 accepts matching extended frames only. 2'b01 accepts matching standard frames only. 2'b00 accepts any matching frame.
- R6: A buffer whose receive flag is set accepts no frame. A frame destined for it is dropped, and neither flag nor hit register changes.
- R7: With `rollover_en` high, a frame that passes buffer 0 while flag 0 is set and flag 1 is clear goes to buffer 1, keeping the buffer-0 hit code (0, 1 or 7). With `rollover_en` low, that frame is dropped.
- R8: `accept_vld`, `accept_buf` and `accept_hit` are valid in the strobe cycle. The chosen buffer's flag sets, and its hit register loads, at the following clock edge. `flag_clr[b]` clears flag b at the next edge and does not free the buffer for a frame in the same cycle.
- R9: After reset both flags and both hit registers are zero.
- R10: With `frame_vld` low, `accept_vld` stays low and no state changes except for flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_vld | input | 1 | Completed-frame strobe |
| frame_ext | input | 1 | 1 = extended identifier, 0 = standard |
| frame_id | input | 29 | Identifier; standard identifiers in bits [10:0] |
| mask0 | input | 29 | Mask for buffer 0 filters |
| mask1 | input | 29 | Mask for buffer 1 filters |
| filt_id | input | 174 | Six filter values, filter i at [i*29 +: 29] |
| filt_ext | input | 6 | Per-filter type select, 1 = extended |
| rx_mode0 | input | 2 | Buffer 0 receive mode |
| rx_mode1 | input | 2 | Buffer 1 receive mode |
| rollover_en | input | 1 | Allow buffer 0 frames into buffer 1 |
| flag_clr | input | 2 | Per-buffer receive-flag clear |
| accept_vld | output | 1 | Frame accepted this cycle |
| accept_buf | output | 1 | Target buffer of the accepted frame |
| accept_hit | output | 3 | Filter index of the accepted frame, 7 = bypass |
| rx_flags | output | 2 | Receive flags, bit b for buffer b |
| buf0_hit | output | 3 | Hit code of the frame held in buffer 0 |
| buf1_hit | output | 3 | Hit code of the frame held in buffer 1 |

## Verification
The properties assume that every input is known after reset and that `frame_vld` stays low during reset. They also assume that masks, filters, modes and the rollover control only change in cycles without a frame strobe. The stimulus changes configuration only between strobes, with the strobe held low. It drives clears and frames in separate or overlapping cycles on purpose, so that locked buffers can be seen rejecting frames. Random frames draw identifiers mostly from the programmed filter values, and they use random upper bits on standard frames, so that matches and near-misses both occur.

// File: rtl/can_rx_accept_filter.sv
module can_rx_accept_filter #(
  parameter int ID_W  = 29,
  parameter int STD_W = 11,
  parameter int NFILT = 6,
  parameter int NF0   = 2,
  parameter int HIT_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_vld,
  input  logic                   frame_ext,
  input  logic [ID_W-1:0]        frame_id,
  input  logic [ID_W-1:0]        mask0,
  input  logic [ID_W-1:0]        mask1,
  input  logic [NFILT*ID_W-1:0]  filt_id,
  input  logic [NFILT-1:0]       filt_ext,
  input  logic [1:0]             rx_mode0,
  input  logic [1:0]             rx_mode1,
  input  logic                   rollover_en,
  input  logic [1:0]             flag_clr,
  output logic                   accept_vld,
  output logic                   accept_buf,
  output logic [HIT_W-1:0]       accept_hit,
  output logic [1:0]             rx_flags,
  output logic [HIT_W-1:0]       buf0_hit,
  output logic [HIT_W-1:0]       buf1_hit
);

  localparam logic [ID_W-1:0]  STD_SEL  = {{(ID_W-STD_W){1'b0}}, {STD_W{1'b1}}};
  localparam logic [HIT_W-1:0] HIT_NONE = '1;

  logic [ID_W-1:0]  cmp_sel;
  logic [NFILT-1:0] f_hit;
  logic [HIT_W-1:0] idx0, idx1, sel0, sel1;
  logic             pass0, pass1;

  assign cmp_sel = frame_ext ? {ID_W{1'b1}} : STD_SEL;

  for (genvar i = 0; i < NFILT; i++) begin : g_filt
    logic [ID_W-1:0] m;
    assign m = (i < NF0) ? mask0 : mask1;
    assign f_hit[i] = (filt_ext[i] == frame_ext) &&
                      (((frame_id ^ filt_id[i*ID_W +: ID_W]) & m & cmp_sel) == '0);
  end

  always_comb begin
    idx0 = '0;
    idx1 = '0;
    for (int i = NF0 - 1; i >= 0; i--)
      if (f_hit[i]) idx0 = HIT_W'(i);
    for (int i = NFILT - 1; i >= NF0; i--)
      if (f_hit[i]) idx1 = HIT_W'(i);
  end

  function automatic logic type_ok(input logic [1:0] mode, input logic ext);
    case (mode)
      2'b10:   return ext;
      2'b01:   return !ext;
      default: return 1'b1;
    endcase
  endfunction

  assign pass0 = frame_vld && ((rx_mode0 == 2'b11) ||
                 (type_ok(rx_mode0, frame_ext) && |f_hit[NF0-1:0]));
  assign pass1 = frame_vld && ((rx_mode1 == 2'b11) ||
                 (type_ok(rx_mode1, frame_ext) && |f_hit[NFILT-1:NF0]));
  assign sel0  = (rx_mode0 == 2'b11) ? HIT_NONE : idx0;
  assign sel1  = (rx_mode1 == 2'b11) ? HIT_NONE : idx1;

  always_comb begin
    accept_vld = 1'b0;
    accept_buf = 1'b0;
    accept_hit = '0;
    if (pass0) begin
      if (!rx_flags[0]) begin
        accept_vld = 1'b1;
        accept_hit = sel0;
      end else if (rollover_en && !rx_flags[1]) begin
        accept_vld = 1'b1;
        accept_buf = 1'b1;
        accept_hit = sel0;
      end
    end else if (pass1 && !rx_flags[1]) begin
      accept_vld = 1'b1;
      accept_buf = 1'b1;
      accept_hit = sel1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_flags <= '0;
      buf0_hit <= '0;
      buf1_hit <= '0;
    end else begin
      rx_flags <= rx_flags & ~flag_clr;
      if (accept_vld) begin
        rx_flags[accept_buf] <= 1'b1;
        if (accept_buf) buf1_hit <= accept_hit;
        else            buf0_hit <= accept_hit;
      end
    end
  end

endmodule

// File: rtl/can_rx_accept_filter_chk.sv
module can_rx_accept_filter_chk #(
  parameter int HIT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_vld,
  input logic [1:0]       rx_mode0,
  input logic             rollover_en,
  input logic             accept_vld,
  input logic             accept_buf,
  input logic [HIT_W-1:0] accept_hit,
  input logic [1:0]       rx_flags
);

  assert_accept_needs_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept_vld |-> frame_vld);

  assert_locked_buffer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_vld |-> !rx_flags[accept_buf]);

  assert_flag_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_vld && !accept_buf) |=> rx_flags[0]);

  assert_flag_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flags[1]) |-> $past(accept_vld && accept_buf));

  assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && rx_mode0 == 2'b11 && !rx_flags[0]) |->
      (accept_vld && !accept_buf && accept_hit == '1));

  assert_no_spill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_vld && accept_buf && !rollover_en) |-> (accept_hit >= HIT_W'(2)));

endmodule

bind can_rx_accept_filter can_rx_accept_filter_chk u_chk (.*);

// File: tb/can_rx_accept_filter_tb.sv
module can_rx_accept_filter_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame_vld = 1'b0, frame_ext = 1'b0;
  logic [28:0]  frame_id = '0, mask0 = '1, mask1 = '1;
  logic [173:0] filt_id = '0;
  logic [5:0]   filt_ext = '0;
  logic [1:0]   rx_mode0 = 2'b00, rx_mode1 = 2'b00, flag_clr = 2'b00;
  logic         rollover_en = 1'b0;
  logic         accept_vld, accept_buf;
  logic [2:0]   accept_hit, buf0_hit, buf1_hit;
  logic [1:0]   rx_flags;

  int checks = 0, failures = 0;
  bit done = 0;
  bit m_flag[2];
  int m_hit[2];

  always #10 clk = ~clk;

  can_rx_accept_filter u_dut (.*);

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit fmatch(input int i);
    logic [28:0] w = frame_ext ? 29'h1FFFFFFF : 29'h7FF;
    logic [28:0] m = (i < 2) ? mask0 : mask1;
    logic [28:0] f = filt_id[i*29 +: 29];
    if (filt_ext[i] != frame_ext) return 0;
    for (int b = 0; b < 29; b++)
      if (w[b] && m[b] && frame_id[b] != f[b]) return 0;
    return 1;
  endfunction

  function automatic void buf_pass(input int b, output bit ok, output int hit);
    logic [1:0] md = b ? rx_mode1 : rx_mode0;
    ok = 0; hit = 0;
    if (!frame_vld) return;
    if (md == 2'b11) begin ok = 1; hit = 7; return; end
    if (md == 2'b10 && !frame_ext) return;
    if (md == 2'b01 && frame_ext) return;
    for (int i = (b ? 5 : 1); i >= (b ? 2 : 0); i--)
      if (fmatch(i)) begin ok = 1; hit = i; end
  endfunction

  task automatic step(input bit v, input bit e, input logic [28:0] id,
                      input logic [1:0] clr, input string tag);
    bit ok0, ok1, ev;
    int h0, h1, eb, eh;
    frame_vld = v; frame_ext = e; frame_id = id; flag_clr = clr;
    #2;
    buf_pass(0, ok0, h0);
    buf_pass(1, ok1, h1);
    ev = 0; eb = 0; eh = 0;
    if (ok0) begin
      if (!m_flag[0]) begin ev = 1; eh = h0; end
      else if (rollover_en && !m_flag[1]) begin ev = 1; eb = 1; eh = h0; end
    end else if (ok1 && !m_flag[1]) begin ev = 1; eb = 1; eh = h1; end
    chk(tag, accept_vld, ev, "accept_vld");
    if (ev) begin
      chk(tag, accept_buf, eb, "accept_buf");
      chk(tag, accept_hit, eh, "accept_hit");
    end
    chk(tag, rx_flags, {m_flag[1], m_flag[0]}, "rx_flags");
    chk(tag, buf0_hit, m_hit[0], "buf0_hit");
    chk(tag, buf1_hit, m_hit[1], "buf1_hit");
    @(posedge clk);
    for (int b = 0; b < 2; b++) if (clr[b]) m_flag[b] = 0;
    if (ev) begin m_flag[eb] = 1; m_hit[eb] = eh; end
    @(negedge clk);
    frame_vld = 0; flag_clr = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    filt_id[0*29 +: 29] = 29'h0A0; filt_id[1*29 +: 29] = 29'h0A1;
    filt_id[2*29 +: 29] = 29'h0A0; filt_id[3*29 +: 29] = 29'h0A3;
    filt_id[4*29 +: 29] = 29'h1234567; filt_id[5*29 +: 29] = 29'h0A5;
    filt_ext = 6'b010000;
    m_flag[0] = 0; m_flag[1] = 0; m_hit[0] = 0; m_hit[1] = 0;
    repeat (3) @(negedge clk);
    chk("R9", rx_flags, 0, "reset rx_flags");
    chk("R9", buf0_hit, 0, "reset buf0_hit");
    chk("R9", buf1_hit, 0, "reset buf1_hit");
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 0, 29'h0A1, 2'b00, "R10");
    step(1, 0, 29'h0A1, 2'b00, "R3");
    step(0, 0, 29'h0, 2'b01, "R8");
    step(1, 0, 29'h0A0, 2'b00, "R4");
    step(1, 0, 29'h0A0, 2'b00, "R6");
    rollover_en = 1;
    step(1, 0, 29'h0A0, 2'b00, "R7");
    step(1, 0, 29'h0A3, 2'b11, "R6");
    step(1, 0, 29'h1FFFF8A3, 2'b10, "R1");
    step(1, 1, 29'h1234567, 2'b10, "R2");
    step(1, 1, 29'h0A0, 2'b00, "R2");
    mask0 = 29'h1FFFFFFE;
    step(1, 0, 29'h0A1, 2'b00, "R1");
    step(0, 0, 29'h0, 2'b01, "R8");
    mask0 = '1; rx_mode0 = 2'b10;
    step(1, 0, 29'h0A0, 2'b00, "R5");
    step(0, 0, 29'h0, 2'b10, "R8");
    rx_mode1 = 2'b11;
    step(1, 1, 29'h0ABCDEF, 2'b10, "R5");
    rx_mode0 = 2'b11;
    step(1, 0, 29'h555, 2'b11, "R5");
    rx_mode0 = 2'b01; rx_mode1 = 2'b10;
    step(1, 1, 29'h0A1, 2'b00, "R5");
    step(0, 0, 29'h0, 2'b11, "R8");
    for (int n = 0; n < 400; n++) begin
      logic [28:0] id;
      if (n % 50 == 0) begin
        rx_mode0 = 2'($urandom); rx_mode1 = 2'($urandom);
        rollover_en = 1'($urandom); mask1 = (n % 100 == 0) ? 29'h1FFFFFF0 : '1;
      end
      id = 29'($urandom);
      if ($urandom % 4 != 0) begin
        int k = $urandom % 6;
        id = filt_id[k*29 +: 29];
        if (!filt_ext[k]) id[28:11] = 18'($urandom);
        if ($urandom % 8 == 0) id[0] = ~id[0];
      end
      step(1'($urandom % 4 != 0), 1'($urandom % 3 == 0), id, 2'($urandom), "R3");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule